// File: doc/BRIEF.md
# System Interrupt Level Router

This block is the system-side interrupt controller of a multiprocessor node. It samples 32 level-sensitive device interrupt lines into a pending register. Each line has a fixed processor interrupt level between 1 and 15, and several lines may share one level. A software disable register masks individual sources and holds one global kill bit. The enabled, pending sources are folded into a 15-bit level vector, and that vector is delivered to the one processor named by a target register. Every other processor sees no hardware level.

Software reaches the block through a simple word-offset register port with a combinational read path. Offset 0 shows pending. Offset 1 shows the disable state. Offset 2 enables sources and offset 3 disables them; both are write-1 operations. Offset 4 holds the target processor. Two one-cycle pulses, a rise and a fall, tell the per-processor banks when a level-15 source asserts or releases, so that each bank can update its own level-15 bit. A raw level view of pending, taken before any masking, is also provided for the target's status display.

Top module: `irq_level_router`

## Requirements
- R1: After reset the disable register holds 0x0FA2007F, pending is zero, the target is 0, every level vector is zero, and reads of offsets 0, 1 and 4 return zero.
- R2: Sources map to levels by bit index as follows. Bits 0..6 and bits 7..13 each map to 2,3,5,7,9,11,13 in that order. Bits 14 and 15 map to 12. Bits 16..22 map to 6,13,4,10,8,9,11. Bits 27..30 map to 15. In a level vector, bit k-1 stands for level k.
- R3: Sources 23..26 and 31 have level 0. They never set pending, never appear in any output and never cause an event.
- R4: Each pending bit with a nonzero level copies its input line at every clock edge, so outputs follow an input one cycle later.
- R5: A write to offset 2 clears the disable bits selected by (data AND 0xF05DFF80). A write to offset 3 sets them. Bits outside that mask never change, and neither write alters pending.
- R6: Offset 0 reads pending with bit 31 forced to 0. Offset 1 reads the disable register ANDed with 0xF05DFF80. Offset 4 reads the target in bits 3..0. Offsets 2, 3, 5, 6 and 7 read 0.
- R7: A write to offset 4 loads the target from data bits 3..0. A target at or above the processor count routes to no processor.
- R8: The target processor's vector is the level map of (pending AND NOT disable). Every other processor's vector is zero.
- R9: While disable bit 31 is set, every processor's level vector is zero and the global kill output is high.
- R10: The raw view is the level map of pending alone, whatever the disable register, the kill bit or the target.
- R11: The rise output pulses for one cycle when any level-15 source (bits 27..30) goes from 0 to 1 in pending. The fall output pulses when any of them goes from 1 to 0.
- R12: Sources 0..6 have disable bits that can never be cleared. They show in the raw view but never reach a processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl_i | input | 32 | Device interrupt lines, level sensitive |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word offset of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| cpu_lvl_o | output | NCPU*15 | Level vectors, 15 bits per processor, processor 0 lowest |
| tgt_raw_lvl_o | output | 15 | Level map of unmasked pending |
| global_kill_o | output | 1 | Disable bit 31 |
| l15_rise_o | output | 1 | Level-15 source assert pulse |
| l15_fall_o | output | 1 | Level-15 source release pulse |

## Verification
A source edge and a register write that changes the disable mask or the target can land on the same clock edge. The level vectors must then reflect both updates together, with no intermediate routing. The random phase provokes this by driving fresh source levels every cycle while writes go out to random offsets, many of them to offsets 2, 3 and 4. After each edge a bench model that mirrors pending, disable and target judges every processor's vector, the raw view, the event pulses and the read data.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int unsigned SRC_W  = 32;
    localparam int unsigned LVL_W  = 15;
    localparam int unsigned TGT_W  = 4;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned KILL_BIT = 31;

    localparam logic [SRC_W-1:0] RST_DISABLE = 32'h0FA2007F;
    localparam logic [SRC_W-1:0] IMPL_MASK   = ~RST_DISABLE;

    typedef enum logic [ADDR_W-1:0] {
        OFF_PENDING = 3'd0,
        OFF_DISRD   = 3'd1,
        OFF_ENABLE  = 3'd2,
        OFF_DISABLE = 3'd3,
        OFF_TARGET  = 3'd4
    } reg_off_e;

    // Fixed source-bit to processor-level table
    function automatic logic [3:0] src_level(input int unsigned b);
        case (b)
            0, 7:            return 4'd2;
            1, 8:            return 4'd3;
            2, 9:            return 4'd5;
            3, 10:           return 4'd7;
            4, 11:           return 4'd9;
            5, 12:           return 4'd11;
            6, 13:           return 4'd13;
            14, 15:          return 4'd12;
            16:              return 4'd6;
            17:              return 4'd13;
            18:              return 4'd4;
            19:              return 4'd10;
            20:              return 4'd8;
            21:              return 4'd9;
            22:              return 4'd11;
            27, 28, 29, 30:  return 4'd15;
            default:         return 4'd0;
        endcase
    endfunction

    // Sources that carry any level at all
    function automatic logic [SRC_W-1:0] live_mask();
        logic [SRC_W-1:0] m;
        for (int unsigned b = 0; b < SRC_W; b++) m[b] = (src_level(b) != 4'd0);
        return m;
    endfunction

    // Sources that feed one given level
    function automatic logic [SRC_W-1:0] level_sources(input int unsigned lvl);
        logic [SRC_W-1:0] m;
        for (int unsigned b = 0; b < SRC_W; b++) m[b] = (int'(src_level(b)) == lvl);
        return m;
    endfunction

    localparam logic [SRC_W-1:0] LIVE_MASK = live_mask();
    localparam logic [SRC_W-1:0] L15_MASK  = level_sources(15);

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    output logic [SRC_W-1:0] pend_o,
    output logic             l15_rise_o,
    output logic             l15_fall_o
);

    logic [SRC_W-1:0] pend_d;
    logic [SRC_W-1:0] pend_q;
    logic             rise_q;
    logic             fall_q;

    // Level-0 sources never reach pending
    assign pend_d = src_i & LIVE_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
            rise_q <= |(pend_d & ~pend_q & L15_MASK);
            fall_q <= |(~pend_d & pend_q & L15_MASK);
        end
    end

    assign pend_o     = pend_q;
    assign l15_rise_o = rise_q;
    assign l15_fall_o = fall_q;

    // R11: a rise pulse implies some level-15 source is now pending
    a_r11_rise_pending: assert property (@(posedge clk) disable iff (!rst_n)
        l15_rise_o |-> ((pend_q & L15_MASK) != '0));

    // R11: a fall pulse implies a level-15 source was pending one cycle before
    a_r11_fall_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        l15_fall_o |-> $past((pend_q & L15_MASK) != '0));

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SRC_W-1:0]  wdata_i,
    input  logic [SRC_W-1:0]  pend_i,
    output logic [SRC_W-1:0]  dis_o,
    output logic [TGT_W-1:0]  tgt_o,
    output logic [SRC_W-1:0]  rdata_o
);

    logic [SRC_W-1:0] dis_q;
    logic [TGT_W-1:0] tgt_q;
    logic [SRC_W-1:0] wmask;
    reg_off_e         off;

    assign off   = reg_off_e'(addr_i);
    assign wmask = wdata_i & IMPL_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= RST_DISABLE;
            tgt_q <= '0;
        end else if (wr_en_i) begin
            case (off)
                OFF_ENABLE:  dis_q <= dis_q & ~wmask;
                OFF_DISABLE: dis_q <= dis_q | wmask;
                OFF_TARGET:  tgt_q <= wdata_i[TGT_W-1:0];
                default:     ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (off)
            OFF_PENDING: rdata_o = pend_i & ~(SRC_W'(1) << KILL_BIT);
            OFF_DISRD:   rdata_o = dis_q & IMPL_MASK;
            OFF_TARGET:  rdata_o = SRC_W'(tgt_q);
            default:     rdata_o = '0;
        endcase
    end

    assign dis_o = dis_q;
    assign tgt_o = tgt_q;

    // R5: bits outside the implemented mask keep their reset value
    a_r5_unimpl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q & ~IMPL_MASK) == RST_DISABLE);

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_router_pkg::*;
(
    input  logic [SRC_W-1:0] vec_i,
    output logic [LVL_W-1:0] lvl_o
);

    // One OR-reduction per level over the sources that share it
    for (genvar l = 1; l <= LVL_W; l++) begin : g_lvl
        localparam logic [SRC_W-1:0] SEL = level_sources(l);
        assign lvl_o[l-1] = |(vec_i & SEL);
    end

endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
    import irq_router_pkg::*;
#(
    parameter int unsigned NCPU = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           src_lvl_i,
    input  logic                  reg_wr_i,
    input  logic [2:0]            reg_addr_i,
    input  logic [31:0]           reg_wdata_i,
    output logic [31:0]           reg_rdata_o,
    output logic [NCPU*15-1:0]    cpu_lvl_o,
    output logic [14:0]           tgt_raw_lvl_o,
    output logic                  global_kill_o,
    output logic                  l15_rise_o,
    output logic                  l15_fall_o
);

    localparam int unsigned OUT_W = NCPU * LVL_W;

    logic [SRC_W-1:0] pend;
    logic [SRC_W-1:0] dis;
    logic [TGT_W-1:0] tgt;
    logic [SRC_W-1:0] eff;
    logic [LVL_W-1:0] routed;
    logic             route_en;
    logic [NCPU-1:0]  cpu_any;

    irq_src_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_lvl_i),
        .pend_o     (pend),
        .l15_rise_o (l15_rise_o),
        .l15_fall_o (l15_fall_o)
    );

    irq_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .pend_i  (pend),
        .dis_o   (dis),
        .tgt_o   (tgt),
        .rdata_o (reg_rdata_o)
    );

    assign eff      = pend & ~dis;
    assign route_en = (eff != '0) && !dis[KILL_BIT];

    irq_level_map u_map_eff (
        .vec_i (eff),
        .lvl_o (routed)
    );

    irq_level_map u_map_raw (
        .vec_i (pend),
        .lvl_o (tgt_raw_lvl_o)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign cpu_lvl_o[c*LVL_W +: LVL_W] =
            (route_en && (tgt == TGT_W'(c))) ? routed : '0;
        assign cpu_any[c] = |cpu_lvl_o[c*LVL_W +: LVL_W];
    end

    assign global_kill_o = dis[KILL_BIT];

    // R8: hardware levels reach at most one processor
    a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_any));

    // R9: the kill bit silences every processor
    a_r9_kill_silences: assert property (@(posedge clk) disable iff (!rst_n)
        global_kill_o |-> (cpu_lvl_o == OUT_W'(0)));

    // R7: an out-of-range target routes nowhere
    a_r7_no_target: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tgt) >= int'(NCPU)) |-> (cpu_lvl_o == OUT_W'(0)));

    // R10: routed levels are always a subset of the raw view
    a_r10_raw_covers: assert property (@(posedge clk) disable iff (!rst_n)
        ((routed & ~tgt_raw_lvl_o) == '0));

    // R5: register writes never disturb pending while sources hold still
    a_r5_write_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && $stable(src_lvl_i)) |=> $stable(pend));

endmodule

// File: tb/sim_irq_level_router.sv
`timescale 1ns/1ps
module sim_irq_level_router;

    localparam int NCPU = 4;
    localparam int OW   = NCPU * 15;
    localparam logic [31:0] B_IMPL = 32'hF05DFF80;
    localparam logic [31:0] B_RST  = 32'h0FA2007F;
    localparam int LIMIT = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   src = '0;
    logic          wr = 1'b0;
    logic [2:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [OW-1:0] cpu_lvl;
    logic [14:0]   raw_lvl;
    logic          kill;
    logic          rise;
    logic          fall;

    int unsigned tbl [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                              6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};

    logic [31:0] pend_m;
    logic [31:0] dis_m;
    logic [3:0]  tgt_m;
    logic        rise_m;
    logic        fall_m;
    int          nchk = 0;
    int          nbad = 0;
    int          cycles = 0;
    bit          done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    irq_level_router #(.NCPU(NCPU)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_lvl_i     (src),
        .reg_wr_i      (wr),
        .reg_addr_i    (addr),
        .reg_wdata_i   (wdata),
        .reg_rdata_o   (rdata),
        .cpu_lvl_o     (cpu_lvl),
        .tgt_raw_lvl_o (raw_lvl),
        .global_kill_o (kill),
        .l15_rise_o    (rise),
        .l15_fall_o    (fall)
    );

    function automatic logic [14:0] bmap(input logic [31:0] v);
        logic [14:0] r = '0;
        for (int b = 0; b < 32; b++)
            if (v[b] && tbl[b] != 0) r[tbl[b]-1] = 1'b1;
        return r;
    endfunction

    function automatic logic [14:0] exp_cpu(input int c);
        logic [31:0] e = pend_m & ~dis_m;
        if (e != 0 && !dis_m[31] && int'(tgt_m) == c && c < NCPU) return bmap(e);
        return '0;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return pend_m & 32'h7FFFFFFF;
            3'd1: return dis_m & B_IMPL;
            3'd4: return {28'd0, tgt_m};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        for (int c = 0; c < NCPU; c++)
            chk(tag, $sformatf("R8 cpu%0d levels", c), 64'(cpu_lvl[c*15 +: 15]), 64'(exp_cpu(c)));
        chk(tag, "R10 raw view", 64'(raw_lvl), 64'(bmap(pend_m)));
        chk(tag, "R9 kill", 64'(kill), 64'(dis_m[31]));
        chk(tag, "R11 rise", 64'(rise), 64'(rise_m));
        chk(tag, "R11 fall", 64'(fall), 64'(fall_m));
        chk(tag, "R6 read data", 64'(rdata), 64'(exp_rd(addr)));
    endtask

    // one clock: drive at negedge, update model, compare after the edge
    task automatic step(input logic [31:0] s, input logic w, input logic [2:0] a,
                        input logic [31:0] d, input string tag);
        logic [31:0] npend;
        logic [31:0] l15 = 32'h78000000;
        src = s; wr = w; addr = a; wdata = d;
        npend  = 32'd0;
        for (int b = 0; b < 32; b++) npend[b] = s[b] && (tbl[b] != 0);
        rise_m = |(npend & ~pend_m & l15);
        fall_m = |(~npend & pend_m & l15);
        if (w) begin
            case (a)
                3'd2: dis_m = dis_m & ~(d & B_IMPL);
                3'd3: dis_m = dis_m | (d & B_IMPL);
                3'd4: tgt_m = d[3:0];
                default: ;
            endcase
        end
        pend_m = npend;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
        compare_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        while (cycles < LIMIT) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        pend_m = '0; dis_m = B_RST; tgt_m = '0; rise_m = 0; fall_m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, readback of offsets 0, 1, 4
        step(32'd0, 0, 3'd0, 32'd0, "R1");
        step(32'd0, 0, 3'd1, 32'd0, "R1");
        chk("R1", "disable readback", 64'(rdata), 64'd0);
        step(32'd0, 0, 3'd4, 32'd0, "R1");

        // R2 / R3 / R12: one source at a time
        for (int b = 0; b < 32; b++) begin
            if (b <= 6) step(32'd1 << b, 0, 3'd0, 32'd0, "R12");
            else if (tbl[b] == 0) step(32'd1 << b, 0, 3'd0, 32'd0, "R3");
            else step(32'd1 << b, 0, 3'd0, 32'd0, "R2");
            step(32'd0, 0, 3'd0, 32'd0, "R4");
        end

        // R5: disable everything while sources are up, pending unchanged
        step(32'hFFFFFFFF, 0, 3'd0, 32'd0, "R4");
        step(32'hFFFFFFFF, 1, 3'd3, 32'hFFFFFFFF, "R5");
        step(32'hFFFFFFFF, 0, 3'd1, 32'd0, "R9");
        chk("R5", "all-disabled readback", 64'(rdata), 64'(B_IMPL));
        // R12: a full enable write leaves sources 0..6 disabled
        step(32'hFFFFFFFF, 1, 3'd2, 32'hFFFFFFFF, "R12");
        step(32'h0000007F, 0, 3'd1, 32'd0, "R12");
        chk("R12", "cpu0 dark for low sources", 64'(cpu_lvl[14:0]), 64'd0);
        // R9: kill with sources live, raw still visible
        step(32'h00FF0F00, 1, 3'd3, 32'h80000000, "R9");
        step(32'h00FF0F00, 1, 3'd2, 32'h80000000, "R9");

        // R7: targets in and out of range
        step(32'h78010F80, 1, 3'd4, 32'd2, "R7");
        step(32'h78010F80, 1, 3'd4, 32'hFFFFFFF3, "R7");
        step(32'h78010F80, 1, 3'd4, 32'd5, "R7");
        chk("R7", "no cpu with target 5", 64'(cpu_lvl), 64'd0);
        step(32'h78010F80, 1, 3'd4, 32'h1F, "R7");
        step(32'h78010F80, 1, 3'd4, 32'd0, "R8");
        // R11: level-15 edges
        step(32'h00000000, 0, 3'd0, 32'd0, "R11");
        step(32'h10000000, 0, 3'd0, 32'd0, "R11");
        step(32'h30000000, 0, 3'd0, 32'd0, "R11");
        step(32'h20000000, 0, 3'd0, 32'd0, "R11");
        // R6: write-only and unused offsets read zero
        for (int a = 2; a < 8; a++) step(32'd0, 0, 3'(a), 32'd0, "R6");

        // random traffic with simultaneous source and register changes
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] s = $urandom();
            logic        w = ($urandom() % 3) == 0;
            logic [2:0]  a = 3'($urandom() % 8);
            logic [31:0] d = $urandom();
            if (a == 3'd4 && ($urandom() % 2) == 0) d = d & 32'h3;
            if (a == 3'd3 && ($urandom() % 2) == 0) d = d & 32'h7FFFFFFF;
            step(s, w, a, d, "R4");
        end

        finish_run();
    end

endmodule